// File: doc/BRIEF.md
# I2C Stuck Bus Recovery Controller

This controller is the digital supervisor of a four-way I2C bus multiplexer. Each downstream channel has its own enable, and any set of enabled channels can be joined to the upstream bus through an external analog switch that follows the `connect_o` output. The block watches the wired-AND of SDA and SCL over the enabled channels. If both lines have not been high together at least once within a timeout window (45 ms by default, counted in system clock cycles), it declares the bus stuck and pulls the active-low fault output down.

When the disconnect-enable input is high, a fault also opens the upstream connection and starts a recovery sequence on the enabled channels. The sequence issues SCL pulses at a parameterised half period. It stops early once SDA reads high at the end of a high phase, and in any case after a fixed maximum number of pulses. It then finishes with a STOP condition. When disconnect-enable is low, a fault only raises the fault flag. All bus outputs are pull-down enables: a line is released whenever it is not driven. The master restores the connection and clears the fault by taking every enable low and then raising one or more of them. This may be done at any time, including in the middle of recovery, which is then abandoned on that same edge.

Top module: `i2c_stuck_recovery`

## Requirements
- R1: While the combined enabled bus shows SDA and SCL high together at least once in every window of TIMEOUT_CYC cycles, fault_n_o stays high and connect_o stays high.
- R2: If a line of an enabled channel goes low and stays low, with the bus idle before that, fault_n_o falls exactly TIMEOUT_CYC+2 rising clock edges after the first edge that samples the low level (two synchronizer stages plus the watchdog count).
- R3: A single cycle of SDA and SCL high together on the combined bus restarts the watchdog window from zero.
- R4: Channels whose enable is low are ignored: a line stuck on a disabled channel never raises a fault.
- R5: With disc_en_i high, the edge that lowers fault_n_o also lowers connect_o, and the recovery pull-downs are driven only on channels whose enable is high.
- R6: Recovery clocking ends after the high phase in which the combined SDA is seen high, so a device that releases SDA after N pulses (N < MAX_PULSES) receives exactly N SCL pulses.
- R7: Recovery never issues more than MAX_PULSES (default 16) SCL pulses.
- R8: After the last recovery pulse a STOP is produced: SCL is held low, SDA is pulled low, SCL is released, then SDA is released while SCL is high. Each phase lasts HALF_CYC cycles, and all pull-downs are released afterwards.
- R9: With disc_en_i low, a fault lowers only fault_n_o: connect_o stays high and no pull-down is ever driven.
- R10: Once all enables have been low on a clock edge, the first later edge with any enable high sets connect_o and fault_n_o high. Dropping only some of the enables and raising them again has no effect.
- R11: A reconnect made during recovery ends it at once: the pull-downs drop with the enables, and none are driven after the reconnect edge.
- R12: After reset, fault_n_o and connect_o are high and no pull-down is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | NCH | Per-channel enable from the master |
| disc_en_i | input | 1 | Permits disconnection and recovery clocking on a fault |
| dn_sda_i | input | NCH | Raw sensed SDA level of each downstream channel |
| dn_scl_i | input | NCH | Raw sensed SCL level of each downstream channel |
| dn_sda_pd_o | output | NCH | Pull-down enable for each downstream SDA |
| dn_scl_pd_o | output | NCH | Pull-down enable for each downstream SCL |
| connect_o | output | 1 | High when upstream and downstream are joined |
| fault_n_o | output | 1 | Stuck-bus fault, active low |

## Verification
The fault is due on the TIMEOUT_CYC+2nd rising edge after the first edge that samples a stuck level. The bench samples one nanosecond after the edge just before that one and after the edge itself, so it can see that the fault is neither early nor late. A reconnect takes effect on the first edge at which an enable is high again after an all-low edge, and the bench samples right after that edge. The pull-downs follow the enables combinationally, so the abort check reads them within the same cycle. Pulse and STOP counts come from a negative-edge monitor of the modelled bus lines and are compared only after a settling time longer than the longest recovery sequence.

// File: rtl/i2c_srec_pkg.sv
package i2c_srec_pkg;
   typedef enum logic [2:0] {
      RS_IDLE,
      RS_SCL_LO,
      RS_SCL_HI,
      RS_STOP_A,
      RS_STOP_B,
      RS_STOP_C
   } rec_state_t;
endpackage

// File: rtl/srec_sync.sv
module srec_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '1;
               else        stage_q[s] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '1;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/srec_watchdog.sv
module srec_watchdog #(
   parameter int TIMEOUT_CYC = 4_500_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_sda,
   input  logic bus_scl,
   input  logic hold,
   input  logic restart,
   output logic expire
);
   localparam int TW = $clog2(TIMEOUT_CYC + 1);

   logic [TW-1:0] cnt_q;
   logic          both_high;

   assign both_high = bus_sda && bus_scl;
   assign expire    = !hold && !restart && !both_high &&
                      (cnt_q == TW'(TIMEOUT_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (restart || both_high) cnt_q <= '0;
      else if (expire)               cnt_q <= '0;
      else if (!hold)                cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/srec_reconnect.sv
module srec_reconnect #(
   parameter int NCH = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] en_i,
   output logic           recon
);
   logic armed_q;

   assign recon = armed_q && (en_i != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              armed_q <= 1'b0;
      else if (en_i == '0)     armed_q <= 1'b1;
      else if (recon)          armed_q <= 1'b0;
   end
endmodule

// File: rtl/srec_recovery.sv
module srec_recovery
   import i2c_srec_pkg::*;
#(
   parameter int HALF_CYC   = 500,
   parameter int MAX_PULSES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic abort,
   input  logic bus_sda,
   output logic drv_scl,
   output logic drv_sda
);
   localparam int CW = $clog2(HALF_CYC + 1);
   localparam int PW = $clog2(MAX_PULSES + 1);

   rec_state_t    state_q;
   logic [CW-1:0] half_q;
   logic [PW-1:0] pulses_q;
   logic          half_done;

   assign half_done = (half_q == CW'(HALF_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= RS_IDLE;
         half_q   <= '0;
         pulses_q <= '0;
      end else if (abort) begin
         state_q  <= RS_IDLE;
         half_q   <= '0;
         pulses_q <= '0;
      end else begin
         half_q <= half_done ? '0 : half_q + 1'b1;
         unique case (state_q)
            RS_IDLE: begin
               half_q   <= '0;
               pulses_q <= '0;
               if (start) state_q <= RS_SCL_LO;
            end
            RS_SCL_LO: if (half_done) state_q <= RS_SCL_HI;
            RS_SCL_HI: if (half_done) begin
               pulses_q <= pulses_q + 1'b1;
               if (bus_sda || pulses_q == PW'(MAX_PULSES - 1))
                  state_q <= RS_STOP_A;
               else
                  state_q <= RS_SCL_LO;
            end
            RS_STOP_A: if (half_done) state_q <= RS_STOP_B;
            RS_STOP_B: if (half_done) state_q <= RS_STOP_C;
            RS_STOP_C: if (half_done) state_q <= RS_IDLE;
            default: state_q <= RS_IDLE;
         endcase
      end
   end

   assign drv_scl = (state_q == RS_SCL_LO) || (state_q == RS_STOP_A) ||
                    (state_q == RS_STOP_B);
   assign drv_sda = (state_q == RS_STOP_B) || (state_q == RS_STOP_C);
endmodule

// File: rtl/i2c_stuck_recovery.sv
module i2c_stuck_recovery #(
   parameter int NCH         = 4,
   parameter int SYNC_STAGES = 2,
   parameter int TIMEOUT_CYC = 4_500_000,
   parameter int HALF_CYC    = 500,
   parameter int MAX_PULSES  = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] en_i,
   input  logic           disc_en_i,
   input  logic [NCH-1:0] dn_sda_i,
   input  logic [NCH-1:0] dn_scl_i,
   output logic [NCH-1:0] dn_sda_pd_o,
   output logic [NCH-1:0] dn_scl_pd_o,
   output logic           connect_o,
   output logic           fault_n_o
);
   localparam int SW = 2 * NCH;

   generate
      if (NCH < 1 || SYNC_STAGES < 2 || TIMEOUT_CYC < 2 ||
          HALF_CYC < 2 || MAX_PULSES < 1) begin : g_bad_cfg
         $error("i2c_stuck_recovery: illegal parameter set");
      end
   endgenerate

   logic [SW-1:0]  sync_q;
   logic [NCH-1:0] sda_s, scl_s, sda_m, scl_m;
   logic           bus_sda, bus_scl;
   logic           expire, recon, drv_scl, drv_sda;
   logic           fault_q, conn_q;

   srec_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({dn_scl_i, dn_sda_i}),
      .q_o   (sync_q)
   );
   assign sda_s = sync_q[NCH-1:0];
   assign scl_s = sync_q[SW-1:NCH];

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         assign sda_m[c]       = sda_s[c] || !en_i[c];
         assign scl_m[c]       = scl_s[c] || !en_i[c];
         assign dn_scl_pd_o[c] = en_i[c] && drv_scl;
         assign dn_sda_pd_o[c] = en_i[c] && drv_sda;
      end
   endgenerate

   assign bus_sda = &sda_m;
   assign bus_scl = &scl_m;

   srec_watchdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wdog (
      .clk     (clk),
      .rst_n   (rst_n),
      .bus_sda (bus_sda),
      .bus_scl (bus_scl),
      .hold    (fault_q),
      .restart (recon),
      .expire  (expire)
   );

   srec_reconnect #(.NCH(NCH)) u_recon (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (en_i),
      .recon (recon)
   );

   srec_recovery #(.HALF_CYC(HALF_CYC), .MAX_PULSES(MAX_PULSES)) u_rec (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (expire && disc_en_i),
      .abort   (recon),
      .bus_sda (bus_sda),
      .drv_scl (drv_scl),
      .drv_sda (drv_sda)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_q <= 1'b0;
         conn_q  <= 1'b1;
      end else if (recon) begin
         fault_q <= 1'b0;
         conn_q  <= 1'b1;
      end else if (expire) begin
         fault_q <= 1'b1;
         if (disc_en_i) conn_q <= 1'b0;
      end
   end

   assign fault_n_o = !fault_q;
   assign connect_o = conn_q;
endmodule

// File: rtl/i2c_stuck_recovery_chk.sv
module i2c_stuck_recovery_chk #(
   parameter int NCH = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic [NCH-1:0] en_i,
   input logic           disc_en_i,
   input logic [NCH-1:0] dn_sda_pd_o,
   input logic [NCH-1:0] dn_scl_pd_o,
   input logic           connect_o,
   input logic           fault_n_o
);
   p_pd_enabled_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((dn_scl_pd_o | dn_sda_pd_o) & ~en_i) == '0);

   p_disc_implies_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !connect_o |-> !fault_n_o);

   p_fault_opens_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(fault_n_o) && $past(disc_en_i)) |-> !connect_o);

   p_fault_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(fault_n_o) && !$past(disc_en_i)) |-> connect_o);

   p_no_drive_connected_r9: assert property (@(posedge clk) disable iff (!rst_n)
      connect_o |-> (dn_scl_pd_o == '0 && dn_sda_pd_o == '0));

   p_clear_on_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_n_o) |-> (en_i != '0 && connect_o));
endmodule

bind i2c_stuck_recovery i2c_stuck_recovery_chk #(.NCH(NCH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .en_i        (en_i),
   .disc_en_i   (disc_en_i),
   .dn_sda_pd_o (dn_sda_pd_o),
   .dn_scl_pd_o (dn_scl_pd_o),
   .connect_o   (connect_o),
   .fault_n_o   (fault_n_o)
);

// File: tb/i2c_stuck_recovery_bench.sv
module i2c_stuck_recovery_bench;
   localparam int NCH = 4;
   localparam int T   = 20;
   localparam int H   = 4;
   localparam int MP  = 16;
   localparam int RWAIT = 2 * H * (MP + 2) + 3 * H + 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NCH-1:0] en = '0;
   logic disc = 1'b0;
   logic [NCH-1:0] stuck = '0;
   logic [NCH-1:0] scl_hold = '0;
   logic [NCH-1:0] sda_dev_low;
   logic [NCH-1:0] sda_line, scl_line;
   logic [NCH-1:0] sda_pd, scl_pd;
   logic connect, fault_n;

   int rel_n = 1000;
   int base = 0;
   int mon_ch = 0;
   int pulse_cnt = 0, stop_cnt = 0, bad_cnt = 0;
   int n_chk = 0, n_err = 0;
   bit p_scl = 1'b1, p_sda = 1'b1, p_sda_pd = 1'b0;

   always #2 clk = ~clk;

   always_comb begin
      for (int i = 0; i < NCH; i++)
         sda_dev_low[i] = stuck[i] && (i != mon_ch || (pulse_cnt - base) < rel_n);
   end
   assign sda_line = ~(sda_pd | sda_dev_low);
   assign scl_line = ~(scl_pd | scl_hold);

   i2c_stuck_recovery #(.NCH(NCH), .TIMEOUT_CYC(T), .HALF_CYC(H),
                        .MAX_PULSES(MP)) u_i2c_stuck_recovery (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_i        (en),
      .disc_en_i   (disc),
      .dn_sda_i    (sda_line),
      .dn_scl_i    (scl_line),
      .dn_sda_pd_o (sda_pd),
      .dn_scl_pd_o (scl_pd),
      .connect_o   (connect),
      .fault_n_o   (fault_n)
   );

   always @(negedge clk) begin
      if (sda_line[mon_ch] && !p_sda && scl_line[mon_ch] && p_scl && p_sda_pd)
         stop_cnt++;
      if (scl_line[mon_ch] && !p_scl && !sda_pd[mon_ch])
         pulse_cnt++;
      if (((scl_pd | sda_pd) & ~en) != '0)
         bad_cnt++;
      p_scl    = scl_line[mon_ch];
      p_sda    = sda_line[mon_ch];
      p_sda_pd = sda_pd[mon_ch];
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic reconnect(input logic [NCH-1:0] mask, input string req);
      @(negedge clk); en = '0;
      @(posedge clk);
      @(negedge clk); en = mask;
      @(posedge clk); #1;
      chk(fault_n == 1'b1, {req, " fault cleared"}, fault_n, 1);
      chk(connect == 1'b1, {req, " connected"}, connect, 1);
   endtask

   task automatic fault_deadline(input string req);
      repeat (T + 1) @(posedge clk); #1;
      chk(fault_n == 1'b1, {req, " no fault one edge early"}, fault_n, 1);
      @(posedge clk); #1;
      chk(fault_n == 1'b0, {req, " fault on deadline"}, fault_n, 0);
   endtask

   task automatic recover_case(input logic [NCH-1:0] mask, input int ch, input int n);
      int sb, bb, exp_p;
      @(negedge clk); en = mask; disc = 1'b1; stuck = '0; mon_ch = ch;
      repeat (6) @(posedge clk);
      @(negedge clk);
      base = pulse_cnt; sb = stop_cnt; bb = bad_cnt; rel_n = n;
      stuck[ch] = 1'b1;
      fault_deadline("R2");
      chk(connect == 1'b0, "R5 disconnect on fault", connect, 0);
      repeat (RWAIT) @(posedge clk); #1;
      exp_p = (n < MP) ? n : MP;
      if (n < MP) chk(pulse_cnt - base == exp_p, "R6 early stop pulses", pulse_cnt - base, exp_p);
      else        chk(pulse_cnt - base == exp_p, "R7 pulse limit", pulse_cnt - base, exp_p);
      chk(stop_cnt - sb == ((n <= MP) ? 1 : 0), "R8 stop condition", stop_cnt - sb, (n <= MP) ? 1 : 0);
      chk(scl_pd == '0 && sda_pd == '0, "R8 released after stop", {sda_pd, scl_pd}, 0);
      chk(bad_cnt == bb, "R5 drive only enabled channels", bad_cnt - bb, 0);
      @(negedge clk); stuck = '0;
      reconnect(mask, "R10");
   endtask

   initial begin
      repeat (5) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      chk(fault_n == 1'b1, "R12 reset fault_n", fault_n, 1);
      chk(connect == 1'b1, "R12 reset connect", connect, 1);
      chk(sda_pd == '0 && scl_pd == '0, "R12 reset pull-downs", {sda_pd, scl_pd}, 0);

      // R1: active traffic with periodic idle, never a fault
      @(negedge clk); en = 4'b0101; disc = 1'b1;
      for (int k = 0; k < 3 * T; k++) begin
         @(negedge clk);
         scl_hold = (k % (T / 2) == 0) ? 4'b0000 : ((k % 2) ? 4'b0001 : 4'b0100);
         stuck    = (k % 3 == 0) ? 4'b0100 : 4'b0000;
         if (k % (T / 2) == 0) stuck = '0;
      end
      @(negedge clk); scl_hold = '0; stuck = '0;
      @(posedge clk); #1;
      chk(fault_n == 1'b1, "R1 no fault with idle seen", fault_n, 1);
      chk(connect == 1'b1, "R1 still connected", connect, 1);

      // R4: stuck line on a disabled channel
      @(negedge clk); en = 4'b0011; stuck = 4'b1000; mon_ch = 3; rel_n = 1000;
      repeat (3 * T) @(posedge clk); #1;
      chk(fault_n == 1'b1, "R4 disabled channel ignored", fault_n, 1);
      chk(sda_pd == '0 && scl_pd == '0, "R4 no drive", {sda_pd, scl_pd}, 0);
      @(negedge clk); stuck = '0; mon_ch = 0;
      repeat (4) @(posedge clk);

      // R3: one idle cycle restarts the window
      @(negedge clk); en = 4'b0001; disc = 1'b0; stuck = 4'b0001; rel_n = 1000; base = pulse_cnt;
      repeat (T - 2) @(posedge clk);
      @(negedge clk); stuck = '0;
      @(negedge clk); stuck = 4'b0001;
      fault_deadline("R3");

      // R9: fault only, no disconnect, no drive
      chk(connect == 1'b1, "R9 stays connected", connect, 1);
      repeat (3 * T) @(posedge clk); #1;
      chk(sda_pd == '0 && scl_pd == '0, "R9 no recovery drive", {sda_pd, scl_pd}, 0);
      chk(fault_n == 1'b0, "R9 fault held", fault_n, 0);

      // R10: partial enable toggle does not clear
      @(negedge clk); stuck = '0; en = 4'b0011;
      @(negedge clk); en = 4'b0001;
      @(negedge clk); en = 4'b0011;
      @(posedge clk); #1;
      chk(fault_n == 1'b0, "R10 partial toggle ignored", fault_n, 0);
      reconnect(4'b0011, "R10");

      // R5..R8 sweep over channel sets and release points
      for (int m = 0; m < 3; m++) begin
         for (int j = 0; j < 5; j++) begin
            logic [NCH-1:0] mask;
            int ch;
            int rel;
            mask = (m == 0) ? 4'b0001 : ((m == 1) ? 4'b0110 : 4'b1111);
            ch   = (m == 1) ? 1 : 0;
            rel  = (j == 0) ? 1 : (j == 1) ? 5 : (j == 2) ? 15 : (j == 3) ? 16 : 20;
            recover_case(mask, ch, rel);
         end
      end

      // R11: early reconnect aborts recovery
      @(negedge clk); en = 4'b0001; disc = 1'b1; mon_ch = 0; rel_n = 1000;
      base = pulse_cnt; stuck = 4'b0001;
      fault_deadline("R11");
      repeat (3 * H) @(posedge clk);
      @(negedge clk); en = '0; #1;
      chk(sda_pd == '0 && scl_pd == '0, "R11 drive drops with enables", {sda_pd, scl_pd}, 0);
      @(posedge clk);
      @(negedge clk); stuck = '0; en = 4'b0001;
      @(posedge clk); #1;
      chk(connect == 1'b1 && fault_n == 1'b1, "R11 immediate reconnect", {connect, fault_n}, 3);
      repeat (2 * H) @(posedge clk); #1;
      chk(sda_pd == '0 && scl_pd == '0, "R11 recovery abandoned", {sda_pd, scl_pd}, 0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule